// File: doc/BRIEF.md
# Busy/Done Polled Device Controller

This block sits on a simple register bus and stands in for a slow peripheral. Software puts a data word into the first data slot and programs an operation length. It then writes the start command. The controller reports itself busy for the programmed number of cycles and then reports itself finished. It raises an interrupt-pending line toward the processor in the same cycle. Software can either poll the two status bits or wait for the interrupt line. It acknowledges completion by writing the done bit, which returns the controller to idle and drops the interrupt line.

A minimal device-side handshake is provided. `dev_start` pulses once when an operation begins. `dev_active` is high for as long as the controller is busy. `dev_word` carries data word 0 to the device. The device can hold `dev_stall` high to freeze the countdown, which stretches the operation by the number of stalled cycles.

Register offsets (one word each):
- 0: command. A write issues a command. A read returns the last accepted command.
- 1: status. Bit 0 is done, bit 1 is busy, and bits 3:2 hold the error code.
- 2 to 2+N_DATA-1: data words 0 to N_DATA-1.
- 2+N_DATA: operation length.

Any other offset reads as zero, and writes to it are dropped.

Top module: `devctl_top`

## Requirements
- R1: After reset, the status register reads 0, `irq_pending`, `dev_active` and `dev_start` are 0, and every data word and the length register read 0.
- R2: A write of command value 1 (start) to offset 0 while status bits 1:0 are 00 makes them 10 at the next clock edge. At that same edge `dev_start` goes high for exactly one cycle and `dev_word` equals data word 0.
- R3: With length L captured at the start and no stall, busy stays set for exactly L+1 cycles, so L=0 completes in one cycle. On the edge where busy clears, done sets and `irq_pending` rises, so status goes from 10 directly to 01.
- R4: Status bits 1:0 never read 11.
- R5: A write to offset 0 or to a data offset while busy or done is set is ignored. The state and the data words do not change, and the error code (status bits 3:2) becomes 1.
- R6: A command value other than 1 written while idle leaves the controller idle and sets error code 2. An accepted start command clears the error code to 0.
- R7: A status write with bit 0 set, made while done is set, returns the controller to idle and clears `irq_pending` at the next edge. A status write with bit 0 clear has no effect.
- R8: Each busy cycle in which `dev_stall` is high freezes the countdown, so the busy period grows by one cycle per stalled cycle.
- R9: While idle, the data words and the length register read back the value last written. Offset 0 reads back the last accepted command. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| dev_stall | input | 1 | Device holds the countdown |
| irq_pending | output | 1 | Completion interrupt toward the processor |
| dev_active | output | 1 | Operation in progress (busy) |
| dev_start | output | 1 | One-cycle pulse at operation start |
| dev_word | output | DW | Data word 0 presented to the device |

## Verification
The assertions check the status rules on every cycle:
- the 11 status combination never appears;
- a falling busy bit is always accompanied by done and the interrupt line;
- the interrupt line rises only with done and falls only with the acknowledge;
- a stalled busy cycle stays busy;
- a start or an unknown command from idle gives the required next state;
- a command in the finished state leaves the controller finished.

Only the bench scenarios can show the following:
- the exact busy length for a captured L, including the stalled cycles;
- that writes ignored during an operation really leave the data words untouched;
- that error codes persist and clear as specified;
- that register readback and unmapped offsets read correctly.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    // status bits {busy, done}
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DONE = 2'b01,
        ST_BUSY = 2'b10
    } dev_state_e;

    localparam logic [1:0] ERR_NONE     = 2'd0;
    localparam logic [1:0] ERR_NOT_IDLE = 2'd1;
    localparam logic [1:0] ERR_BAD_CMD  = 2'd2;

    localparam int CMD_START = 1;

endpackage

// File: rtl/devctl_seq.sv
module devctl_seq
    import devctl_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic [DW-1:0]   cmd_val,
    input  logic            data_wr,
    input  logic            stat_wr,
    input  logic            stat_ack,
    input  logic [CNTW-1:0] len_cfg,
    input  logic            dev_stall,
    output logic [1:0]      state_o,
    output logic [1:0]      err_o,
    output logic            irq_o,
    output logic            start_o,
    output logic [DW-1:0]   last_cmd_o
);

    typedef struct packed {
        dev_state_e      state;
        logic [CNTW-1:0] cnt;
        logic [1:0]      err;
        logic            irq;
        logic            start;
        logic [DW-1:0]   last_cmd;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_val == DW'(CMD_START)) begin
                        seq_d.state    = ST_BUSY;
                        seq_d.cnt      = len_cfg;
                        seq_d.err      = ERR_NONE;
                        seq_d.start    = 1'b1;
                        seq_d.last_cmd = cmd_val;
                    end else begin
                        seq_d.err = ERR_BAD_CMD;
                    end
                end
            end
            ST_BUSY: begin
                if (cmd_wr || data_wr) begin
                    seq_d.err = ERR_NOT_IDLE;
                end
                if (!dev_stall) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.state = ST_DONE;
                        seq_d.irq   = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNTW'(1);
                    end
                end
            end
            ST_DONE: begin
                if (cmd_wr || data_wr) begin
                    seq_d.err = ERR_NOT_IDLE;
                end
                if (stat_wr && stat_ack) begin
                    seq_d.state = ST_IDLE;
                    seq_d.irq   = 1'b0;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.irq   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state    <= ST_IDLE;
            seq_q.cnt      <= '0;
            seq_q.err      <= ERR_NONE;
            seq_q.irq      <= 1'b0;
            seq_q.start    <= 1'b0;
            seq_q.last_cmd <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o    = seq_q.state;
    assign err_o      = seq_q.err;
    assign irq_o      = seq_q.irq;
    assign start_o    = seq_q.start;
    assign last_cmd_o = seq_q.last_cmd;

endmodule

// File: rtl/devctl_regs.sv
module devctl_regs #(
    parameter int DW     = 16,
    parameter int N_DATA = 4,
    parameter int CNTW   = 8,
    parameter int IDXW   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       data_we,
    input  logic [IDXW-1:0]            data_idx,
    input  logic                       len_we,
    input  logic [DW-1:0]              wdata,
    output logic [N_DATA-1:0][DW-1:0]  words_o,
    output logic [CNTW-1:0]            len_o
);

    typedef struct packed {
        logic [N_DATA-1:0][DW-1:0] words;
        logic [CNTW-1:0]           len;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [N_DATA-1:0] word_we;

    for (genvar g = 0; g < N_DATA; g++) begin : g_word_sel
        assign word_we[g] = data_we && (data_idx == IDXW'(g));
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N_DATA; i++) begin
            if (word_we[i]) begin
                regs_d.words[i] = wdata;
            end
        end
        if (len_we) begin
            regs_d.len = wdata[CNTW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign words_o = regs_q.words;
    assign len_o   = regs_q.len;

endmodule

// File: rtl/devctl_rdmux.sv
module devctl_rdmux #(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int N_DATA = 4,
    parameter int CNTW   = 8
) (
    input  logic [AW-1:0]              addr,
    input  logic [1:0]                 state,
    input  logic [1:0]                 err,
    input  logic [DW-1:0]              last_cmd,
    input  logic [N_DATA-1:0][DW-1:0]  words,
    input  logic [CNTW-1:0]            len,
    output logic [DW-1:0]              rdata
);

    localparam int LEN_OFS = 2 + N_DATA;

    always_comb begin
        rdata = '0;
        if (addr == AW'(0)) begin
            rdata = last_cmd;
        end else if (addr == AW'(1)) begin
            rdata[3:0] = {err, state};
        end else if (addr == AW'(LEN_OFS)) begin
            rdata[CNTW-1:0] = len;
        end else begin
            for (int i = 0; i < N_DATA; i++) begin
                if (addr == AW'(2 + i)) begin
                    rdata = words[i];
                end
            end
        end
    end

endmodule

// File: rtl/devctl_top.sv
module devctl_top #(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int N_DATA = 4,
    parameter int CNTW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dev_stall,
    output logic          irq_pending,
    output logic          dev_active,
    output logic          dev_start,
    output logic [DW-1:0] dev_word
);

    localparam int LEN_OFS = 2 + N_DATA;
    localparam int IDXW    = (N_DATA > 1) ? $clog2(N_DATA) : 1;

    logic                      sel_cmd, sel_stat, sel_data, sel_len;
    logic [IDXW-1:0]           data_idx;
    logic [AW-1:0]             data_ofs;
    logic [1:0]                st_w, err_w;
    logic [DW-1:0]             last_cmd_w;
    logic [N_DATA-1:0][DW-1:0] words_w;
    logic [CNTW-1:0]           len_w;
    logic                      idle_w;

    assign sel_cmd  = (bus_addr == AW'(0));
    assign sel_stat = (bus_addr == AW'(1));
    assign sel_len  = (bus_addr == AW'(LEN_OFS));
    assign sel_data = (bus_addr >= AW'(2)) && (bus_addr < AW'(LEN_OFS));
    assign data_ofs = bus_addr - AW'(2);
    assign data_idx = data_ofs[IDXW-1:0];
    assign idle_w   = (st_w == 2'b00);

    devctl_seq #(.DW(DW), .CNTW(CNTW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (bus_wr && sel_cmd),
        .cmd_val    (bus_wdata),
        .data_wr    (bus_wr && sel_data),
        .stat_wr    (bus_wr && sel_stat),
        .stat_ack   (bus_wdata[0]),
        .len_cfg    (len_w),
        .dev_stall  (dev_stall),
        .state_o    (st_w),
        .err_o      (err_w),
        .irq_o      (irq_pending),
        .start_o    (dev_start),
        .last_cmd_o (last_cmd_w)
    );

    devctl_regs #(.DW(DW), .N_DATA(N_DATA), .CNTW(CNTW), .IDXW(IDXW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_we  (bus_wr && sel_data && idle_w),
        .data_idx (data_idx),
        .len_we   (bus_wr && sel_len),
        .wdata    (bus_wdata),
        .words_o  (words_w),
        .len_o    (len_w)
    );

    devctl_rdmux #(.DW(DW), .AW(AW), .N_DATA(N_DATA), .CNTW(CNTW)) i_rdmux (
        .addr     (bus_addr),
        .state    (st_w),
        .err      (err_w),
        .last_cmd (last_cmd_w),
        .words    (words_w),
        .len      (len_w),
        .rdata    (bus_rdata)
    );

    assign dev_active = st_w[1];
    assign dev_word   = words_w[0];

endmodule

// File: rtl/devctl_chk.sv
module devctl_chk #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          dev_stall,
    input logic [1:0]    state,
    input logic [1:0]    err,
    input logic          irq_pending,
    input logic          dev_start
);

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == AW'(0));

    a_r4_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b11);

    a_r3_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state[1]) |-> (state == 2'b01) && irq_pending);

    a_r3_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> (state == 2'b01));

    a_r7_irq_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state[0]) |-> !irq_pending && (state == 2'b00));

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b00 && cmd_wr && bus_wdata == DW'(1)) |=> (state == 2'b10) && dev_start);

    a_r6_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b00 && cmd_wr && bus_wdata != DW'(1)) |=> (state == 2'b00) && (err == 2'd2));

    a_r5_cmd_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01 && cmd_wr) |=> (state == 2'b01) && (err == 2'd1));

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10 && dev_stall) |=> (state == 2'b10));

endmodule

bind devctl_top devctl_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .dev_stall   (dev_stall),
    .state       (st_w),
    .err         (err_w),
    .irq_pending (irq_pending),
    .dev_start   (dev_start)
);

// File: tb/test_devctl_top.sv
`timescale 1ns/100ps
module test_devctl_top;

    localparam int DW = 16, AW = 4, N = 4, CW = 8;
    localparam int LEN_OFS = 2 + N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          dev_stall = 1'b0;
    logic          irq_pending, dev_active, dev_start;
    logic [DW-1:0] dev_word;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] exp_words [N];
    logic [DW-1:0] exp_cmd = '0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;

    devctl_top #(.DW(DW), .AW(AW), .N_DATA(N), .CNTW(CW)) i_devctl_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_stall(dev_stall),
        .irq_pending(irq_pending), .dev_active(dev_active),
        .dev_start(dev_start), .dev_word(dev_word)
    );

    function automatic logic [DW-1:0] exp_status(logic busy, logic done, logic [1:0] err);
        return DW'({err, busy, done});
    endfunction

    function automatic int exp_busy_len(int len, int stalls);
        return len + 1 + stalls;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] val);
        bus_addr = AW'(addr);
        #0.5;
        val = bus_rdata;
    endtask

    task automatic run_op(input int len, input bit use_stall, input bit inject);
        logic [DW-1:0] v, d0;
        int nb, ns;
        d0 = DW'($urandom);
        wr(2, d0); exp_words[0] = d0;
        wr(LEN_OFS, DW'(len));
        wr(0, DW'(1)); exp_cmd = DW'(1);
        chk(dev_start == 1'b1, "R2 start pulse", int'(dev_start), 1);
        chk(dev_word == d0, "R2 dev_word", int'(dev_word), int'(d0));
        rd(1, v);
        chk(v == exp_status(1, 0, 2'd0), "R2/R6 busy status", int'(v), int'(exp_status(1, 0, 2'd0)));
        nb = 0; ns = 0;
        while (dev_active && nb < 2000) begin
            nb++;
            if (nb == 2) chk(dev_start == 1'b0, "R2 pulse one cycle", int'(dev_start), 0);
            dev_stall = use_stall && ($urandom % 3 == 0);
            if (dev_stall) ns++;
            if (inject && nb == 1) begin
                bus_wr = 1'b1; bus_addr = AW'(3); bus_wdata = ~exp_words[1];
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        dev_stall = 1'b0; bus_wr = 1'b0;
        chk(nb == exp_busy_len(len, ns), "R3/R8 busy length", nb, exp_busy_len(len, ns));
        rd(1, v);
        chk(v == exp_status(0, 1, inject ? 2'd1 : 2'd0), "R3/R5 done status", int'(v),
            int'(exp_status(0, 1, inject ? 2'd1 : 2'd0)));
        chk(irq_pending == 1'b1, "R3 irq raised", int'(irq_pending), 1);
        if (inject) begin
            rd(3, v);
            chk(v == exp_words[1], "R5 data write ignored when busy", int'(v), int'(exp_words[1]));
            wr(0, DW'(1));
            rd(1, v);
            chk(v == exp_status(0, 1, 2'd1), "R5 command ignored when done", int'(v),
                int'(exp_status(0, 1, 2'd1)));
        end
        wr(1, DW'(0));
        rd(1, v);
        chk(v[1:0] == 2'b01 && irq_pending, "R7 write without done bit ignored", int'(v[1:0]), 1);
        wr(1, DW'(1));
        rd(1, v);
        chk(v[1:0] == 2'b00, "R7 ack to idle", int'(v[1:0]), 0);
        chk(irq_pending == 1'b0, "R7 irq cleared", int'(irq_pending), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        seed_v = 32'h5eed_0042;
        void'($urandom(seed_v));
        for (int i = 0; i < N; i++) exp_words[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1, v);
        chk(v == '0, "R1 status at reset", int'(v), 0);
        chk(!irq_pending && !dev_active && !dev_start, "R1 outputs at reset",
            int'({irq_pending, dev_active, dev_start}), 0);
        for (int i = 0; i < N; i++) begin
            rd(2 + i, v);
            chk(v == '0, "R1 data word at reset", int'(v), 0);
        end
        rd(LEN_OFS, v);
        chk(v == '0, "R1 length at reset", int'(v), 0);

        // R9 readback
        for (int i = 0; i < N; i++) begin
            exp_words[i] = DW'($urandom);
            wr(2 + i, exp_words[i]);
        end
        for (int i = 0; i < N; i++) begin
            rd(2 + i, v);
            chk(v == exp_words[i], "R9 data readback", int'(v), int'(exp_words[i]));
        end
        wr(LEN_OFS, DW'(16'h00a5));
        rd(LEN_OFS, v);
        chk(v == DW'(16'h00a5), "R9 length readback", int'(v), 16'h00a5);
        rd(LEN_OFS + 1, v);
        chk(v == '0, "R9 unmapped reads zero", int'(v), 0);
        rd(15, v);
        chk(v == '0, "R9 top offset reads zero", int'(v), 0);

        // R6 unknown command
        wr(0, DW'(5));
        rd(1, v);
        chk(v == exp_status(0, 0, 2'd2), "R6 unknown command", int'(v), int'(exp_status(0, 0, 2'd2)));
        rd(0, v);
        chk(v == exp_cmd, "R9 command readback after reject", int'(v), int'(exp_cmd));

        // directed boundaries
        run_op(0, 1'b0, 1'b0);
        run_op(255, 1'b0, 1'b0);
        run_op(3, 1'b1, 1'b1);
        rd(0, v);
        chk(v == DW'(1), "R9 command readback", int'(v), 1);

        // random operations
        for (int k = 0; k < 24; k++) begin
            run_op(int'($urandom % 8), 1'b1, ($urandom % 2) == 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule